// File: doc/BRIEF.md
# Single-Channel DMA Setup and Sequencer

This block is the control front end of one DMA channel. Software loads a source register and a destination register, then writes one 24-bit control word. That word carries a byte count and the address-space selections for each side. An idle channel starts a transfer when it receives a control word with a non-zero count. The channel then moves the data one byte at a time over an abstract memory port. For each byte it issues a read on the source side, waits for the returned byte, and issues a write on the destination side. Every request is tagged with its address space: register or memory, and internal or external system bus.

In fill mode the source register is not an address. Its low byte is the constant written to every destination byte, and no reads are issued. A control word that selects register space together with system space on either side is illegal. Such a word is refused and raises an error flag; no transfer starts. A clean finish raises a done flag. A busy flag and the remaining byte count can be read at any time.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the channel is idle: `busy`, `done_sts` and `err_sts` are 0, `count_o` is 0 and `mem_req` is 0.
- R2: The byte count is control-word bits [15:0]. A control write with a non-zero count and a legal space selection, made while idle, sets `busy` and loads `count_o` with the count by the next cycle.
- R3: Bit 17 set selects source register space and bit 16 set selects source system space. Bit 21 and bit 20 make the same two selections for the destination. Each read request carries the source selections on `mem_reg`/`mem_sys`, and each write request carries the destination selections. No request has both `mem_reg` and `mem_sys` set.
- R4: Without fill mode, each byte is one read request (`mem_we`=0) to the source, followed by one write request (`mem_we`=1) to the destination whose `mem_wdata` equals the byte returned with `mem_rvalid`.
- R5: The address of byte i is the loaded base plus i on both sides.
- R6: With bit 19 set (fill mode), no read request is issued. Every write carries bits [7:0] of the source register, and the source address does not advance.
- R7: `count_o` drops by one for each accepted write and is 0 when the transfer ends.
- R8: In the cycle after the last write is accepted, `busy` is 0 and `done_sts` is 1.
- R9: An idle control write that sets bit 17 with bit 16, or bit 21 with bit 20, starts nothing. It sets `err_sts`, clears `done_sts`, issues no request and leaves `count_o` unchanged.
- R10: While `busy` is set, control writes and source/destination register writes are ignored. The running transfer keeps its length and its addresses.
- R11: A launch clears `done_sts` and `err_sts`. An idle, legal control write with a zero count changes nothing.
- R12: A request that is not granted stays asserted with the same address, direction and data until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_word | input | 24 | Control word: count and space/mode selections |
| src_we | input | 1 | Source register write strobe |
| src_wdata | input | ADDR_W | Source address or fill value |
| dst_we | input | 1 | Destination register write strobe |
| dst_wdata | input | ADDR_W | Destination start address |
| mem_req | output | 1 | Request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_sys | output | 1 | Request targets the system bus |
| mem_reg | output | 1 | Request targets register space |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read byte returned |
| mem_rdata | input | 8 | Returned byte |
| busy | output | 1 | Transfer in progress |
| done_sts | output | 1 | Last transfer finished cleanly |
| err_sts | output | 1 | Last control write was refused |
| count_o | output | 16 | Bytes still to move |

## Verification
The assertions assume a well-behaved memory port. `mem_gnt` is meaningful only while `mem_req` is high. `mem_rvalid` pulses exactly once per granted read, at least one cycle after the grant, and never while a request is pending. The bench's responder follows these rules by construction. It grants at random only when a request is present. It returns each read after a random delay of one to three cycles, holding a single outstanding read at a time. Random space selections are drawn only from legal combinations; the illegal words are applied only in directed cases.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int unsigned CTRL_W   = 24;
    localparam int unsigned CNT_W    = 16;
    localparam int unsigned BYTE_W   = 8;

    // control word field positions (decoded by the channel)
    localparam int unsigned B_SRC_SYS = 16;
    localparam int unsigned B_SRC_REG = 17;
    localparam int unsigned B_FILL    = 19;
    localparam int unsigned B_DST_SYS = 20;
    localparam int unsigned B_DST_REG = 21;

    typedef struct packed {
        logic src_sys;
        logic src_reg;
        logic fill;
        logic dst_sys;
        logic dst_reg;
    } chan_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REQ  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_WR_REQ  = 2'd3
    } seq_state_t;

    function automatic chan_mode_t get_mode(input logic [CTRL_W-1:0] w);
        chan_mode_t m;
        m.src_sys = w[B_SRC_SYS];
        m.src_reg = w[B_SRC_REG];
        m.fill    = w[B_FILL];
        m.dst_sys = w[B_DST_SYS];
        m.dst_reg = w[B_DST_REG];
        return m;
    endfunction

    // register space is not reachable over the system bus
    function automatic logic mode_illegal(input chan_mode_t m);
        return (m.src_sys & m.src_reg) | (m.dst_sys & m.dst_reg);
    endfunction

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
    import dma_chan_pkg::*;
(
    input  logic [CTRL_W-1:0] cfg_word,
    output chan_mode_t        mode,
    output logic [CNT_W-1:0]  count,
    output logic              illegal,
    output logic              nonzero
);
    logic unused_cfg_bits;

    assign mode            = get_mode(cfg_word);
    assign count           = cfg_word[CNT_W-1:0];
    assign illegal         = mode_illegal(mode);
    assign nonzero         = |cfg_word[CNT_W-1:0];
    assign unused_cfg_bits = ^{cfg_word[CTRL_W-1:B_DST_REG+1], cfg_word[B_FILL-1]};
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_wr,
    input  logic [ADDR_W-1:0] src_wdata,
    input  logic              dst_wr,
    input  logic [ADDR_W-1:0] dst_wdata,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    input  logic              fill,
    input  logic              busy,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic              last_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr  <= '0;
            dst_addr  <= '0;
            remaining <= '0;
        end else begin
            if (src_wr)
                src_addr <= src_wdata;
            else if (step && !fill)
                src_addr <= src_addr + ADDR_W'(1);

            if (dst_wr)
                dst_addr <= dst_wdata;
            else if (step)
                dst_addr <= dst_addr + ADDR_W'(1);

            if (load)
                remaining <= load_cnt;
            else if (step)
                remaining <= remaining - CNT_W'(1);
        end
    end

    assign last_byte = (remaining == CNT_W'(1));

    assert_cnt_dec_R7: assert property (@(posedge clk) disable iff (rst)
        step |=> remaining == $past(remaining) - CNT_W'(1));

    assert_fill_src_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (step && fill) |=> $stable(src_addr));

    assert_addr_inc_R5: assert property (@(posedge clk) disable iff (rst)
        step |=> dst_addr == $past(dst_addr) + ADDR_W'(1));

    assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !step) |=> ($stable(remaining) && $stable(src_addr) && $stable(dst_addr)));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              reject,
    input  chan_mode_t        mode_in,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              last_byte,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_sys,
    output logic              mem_reg,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              step,
    output logic              fill_act,
    output logic              busy,
    output logic              done_sts,
    output logic              err_sts
);
    seq_state_t  state_q;
    chan_mode_t  mode_q;
    logic [BYTE_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    mode_q  <= mode_in;
                    state_q <= mode_in.fill ? ST_WR_REQ : ST_RD_REQ;
                end
                ST_RD_REQ: if (mem_gnt) state_q <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rvalid) begin
                    data_q  <= mem_rdata;
                    state_q <= ST_WR_REQ;
                end
                ST_WR_REQ: if (mem_gnt) begin
                    if (last_byte)        state_q <= ST_IDLE;
                    else if (mode_q.fill) state_q <= ST_WR_REQ;
                    else                  state_q <= ST_RD_REQ;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_sts <= 1'b0;
            err_sts  <= 1'b0;
        end else if (launch) begin
            done_sts <= 1'b0;
            err_sts  <= 1'b0;
        end else if (reject) begin
            done_sts <= 1'b0;
            err_sts  <= 1'b1;
        end else if (step && last_byte) begin
            done_sts <= 1'b1;
        end
    end

    always_comb begin
        mem_req   = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
        mem_we    = (state_q == ST_WR_REQ);
        mem_sys   = mem_we ? mode_q.dst_sys : mode_q.src_sys;
        mem_reg   = mem_we ? mode_q.dst_reg : mode_q.src_reg;
        mem_addr  = mem_we ? dst_addr : src_addr;
        mem_wdata = mode_q.fill ? src_addr[BYTE_W-1:0] : data_q;
        step      = (state_q == ST_WR_REQ) && mem_gnt;
        busy      = (state_q != ST_IDLE);
        fill_act  = mode_q.fill;
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_no_io_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_sys) |-> !mem_reg);

    assert_fill_no_read_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !fill_act);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (step && last_byte) |=> (!busy && done_sts));

    assert_reject_R9: assert property (@(posedge clk) disable iff (rst)
        reject |=> (err_sts && !busy && !mem_req));

    assert_launch_clears_R11: assert property (@(posedge clk) disable iff (rst)
        launch |=> (busy && !done_sts && !err_sts));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [23:0]       cfg_word,
    input  logic              src_we,
    input  logic [ADDR_W-1:0] src_wdata,
    input  logic              dst_we,
    input  logic [ADDR_W-1:0] dst_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_sys,
    output logic              mem_reg,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done_sts,
    output logic              err_sts,
    output logic [15:0]       count_o
);
    chan_mode_t        dec_mode;
    logic [CNT_W-1:0]  dec_count;
    logic              dec_illegal;
    logic              dec_nonzero;
    logic              accept, launch, reject;
    logic              step, fill_act, last_byte;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    dma_cfg_decode u_dec (
        .cfg_word (cfg_word),
        .mode     (dec_mode),
        .count    (dec_count),
        .illegal  (dec_illegal),
        .nonzero  (dec_nonzero)
    );

    assign accept = cfg_we && !busy;
    assign launch = accept && dec_nonzero && !dec_illegal;
    assign reject = accept && dec_illegal;

    dma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .src_wr    (src_we && !busy),
        .src_wdata (src_wdata),
        .dst_wr    (dst_we && !busy),
        .dst_wdata (dst_wdata),
        .load      (launch),
        .load_cnt  (dec_count),
        .step      (step),
        .fill      (fill_act),
        .busy      (busy),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .remaining (count_o),
        .last_byte (last_byte)
    );

    dma_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .reject     (reject),
        .mode_in    (dec_mode),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .last_byte  (last_byte),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_sys    (mem_sys),
        .mem_reg    (mem_reg),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .step       (step),
        .fill_act   (fill_act),
        .busy       (busy),
        .done_sts   (done_sts),
        .err_sts    (err_sts)
    );

    assert_launch_load_R2: assert property (@(posedge clk) disable iff (rst)
        launch |=> (busy && count_o == $past(cfg_word[15:0])));

    assert_reject_count_R9: assert property (@(posedge clk) disable iff (rst)
        reject |=> $stable(count_o));
endmodule

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        src_we = 1'b0, dst_we = 1'b0;
    logic [31:0] src_wdata = '0, dst_wdata = '0;
    logic        mem_req, mem_we, mem_sys, mem_reg;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done_sts, err_sts;
    logic [15:0] count_o;

    always #10 clk = ~clk;

    dma_chan_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .src_we(src_we), .src_wdata(src_wdata), .dst_we(dst_we), .dst_wdata(dst_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_sys(mem_sys), .mem_reg(mem_reg),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done_sts(done_sts), .err_sts(err_sts), .count_o(count_o)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // expectations for the running transfer
    int          exp_len = 0, wr_idx = 0, rd_idx = 0;
    logic [31:0] exp_src = '0, exp_dst = '0;
    bit          exp_fill = 0, e_ssys = 0, e_sreg = 0, e_dsys = 0, e_dreg = 0;
    bit          rd_pend = 0;
    int          rd_delay = 0;
    logic [7:0]  rd_byte = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a, input bit sys, input bit rg);
        return a[7:0] ^ a[15:8] ^ (sys ? 8'hA5 : 8'h00) ^ (rg ? 8'h3C : 8'h00);
    endfunction

    function automatic logic [23:0] mk_cfg(input logic [15:0] len, input bit ssys, input bit sreg,
                                           input bit fill, input bit dsys, input bit dreg);
        return {2'b00, dreg, dsys, fill, 1'b0, sreg, ssys, len};
    endfunction

    // memory responder and per-request checker
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (rd_pend) begin
                if (rd_delay == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd_byte;
                    rd_pend    = 0;
                end else rd_delay--;
            end
            mem_gnt = mem_req && ($urandom % 4 != 0);
            if (mem_req && mem_gnt) begin
                if (!mem_we) begin
                    chk(!exp_fill, "R6", "read issued in fill mode", 32'(mem_we), 32'd1);
                    chk(mem_addr == exp_src + 32'(rd_idx), "R5", "read address", mem_addr, exp_src + 32'(rd_idx));
                    chk({mem_sys, mem_reg} == {e_ssys, e_sreg}, "R3", "read space", 32'({mem_sys, mem_reg}), 32'({e_ssys, e_sreg}));
                    chk(rd_idx == wr_idx, "R4", "read order", 32'(rd_idx), 32'(wr_idx));
                    rd_byte  = mem_byte(mem_addr, mem_sys, mem_reg);
                    rd_delay = int'($urandom % 3);
                    rd_pend  = 1;
                    rd_idx++;
                end else begin
                    logic [7:0] ed;
                    ed = exp_fill ? exp_src[7:0]
                                  : mem_byte(exp_src + 32'(wr_idx), e_ssys, e_sreg);
                    chk(mem_addr == exp_dst + 32'(wr_idx), "R5", "write address", mem_addr, exp_dst + 32'(wr_idx));
                    chk(mem_wdata == ed, exp_fill ? "R6" : "R4", "write data", 32'(mem_wdata), 32'(ed));
                    chk({mem_sys, mem_reg} == {e_dsys, e_dreg}, "R3", "write space", 32'({mem_sys, mem_reg}), 32'({e_dsys, e_dreg}));
                    chk(32'(count_o) == 32'(exp_len - wr_idx), "R7", "count before write", 32'(count_o), 32'(exp_len - wr_idx));
                    wr_idx++;
                end
            end
        end
    end

    task automatic write_regs(input logic [31:0] s, input logic [31:0] d);
        @(negedge clk); src_we = 1; src_wdata = s;
        @(negedge clk); src_we = 0; dst_we = 1; dst_wdata = d;
        @(negedge clk); dst_we = 0;
    endtask

    task automatic start_xfer(input int len, input logic [31:0] s, input logic [31:0] d,
                              input bit ssys, input bit sreg, input bit fill, input bit dsys, input bit dreg);
        write_regs(s, d);
        exp_len = len; wr_idx = 0; rd_idx = 0; exp_src = s; exp_dst = d;
        exp_fill = fill; e_ssys = ssys; e_sreg = sreg; e_dsys = dsys; e_dreg = dreg;
        cfg_word = mk_cfg(16'(len), ssys, sreg, fill, dsys, dreg);
        cfg_we = 1;
        @(negedge clk); cfg_we = 0;
        chk(busy == 1'b1, "R2", "busy after launch", 32'(busy), 32'd1);
        chk(done_sts == 1'b0 && err_sts == 1'b0, "R11", "status cleared on launch",
            32'({done_sts, err_sts}), 32'd0);
        chk(32'(count_o) == 32'(len) || wr_idx > 0, "R2", "count loaded", 32'(count_o), 32'(len));
    endtask

    task automatic finish_xfer();
        while (busy) @(negedge clk);
        chk(done_sts == 1'b1 && err_sts == 1'b0, "R8", "done after last write", 32'({done_sts, err_sts}), 32'd2);
        chk(count_o == 16'd0, "R7", "count at end", 32'(count_o), 32'd0);
        chk(wr_idx == exp_len, "R8", "write total", 32'(wr_idx), 32'(exp_len));
        chk(rd_idx == (exp_fill ? 0 : exp_len), exp_fill ? "R6" : "R4", "read total",
            32'(rd_idx), 32'(exp_fill ? 0 : exp_len));
    endtask

    task automatic expect_reject(input logic [23:0] w);
        logic [15:0] c0;
        c0 = count_o;
        cfg_word = w; cfg_we = 1;
        @(negedge clk); cfg_we = 0;
        chk(err_sts == 1'b1 && done_sts == 1'b0, "R9", "error flag", 32'({err_sts, done_sts}), 32'd2);
        chk(busy == 1'b0, "R9", "no launch", 32'(busy), 32'd0);
        chk(count_o == c0, "R9", "count unchanged", 32'(count_o), 32'(c0));
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(mem_req == 1'b0, "R9", "no request after reject", 32'(mem_req), 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && done_sts == 0 && err_sts == 0, "R1", "reset status",
            32'({busy, done_sts, err_sts}), 32'd0);
        chk(count_o == 0 && mem_req == 0, "R1", "reset count/request", 32'({count_o, mem_req}), 32'd0);

        // directed: one byte, memory to memory
        start_xfer(1, 32'h0000_1000, 32'h0000_2000, 0, 0, 0, 0, 0); finish_xfer();
        // directed: fill into system memory
        start_xfer(7, 32'h1234_56C3, 32'h8000_00FE, 0, 0, 1, 1, 0); finish_xfer();
        // directed: register source to system destination across a byte carry
        start_xfer(20, 32'h0000_00F8, 32'hFFFF_FFF4, 0, 1, 0, 1, 0); finish_xfer();
        // directed: illegal destination, then illegal source
        expect_reject(mk_cfg(16'd4, 0, 0, 0, 1, 1));
        expect_reject(mk_cfg(16'd4, 1, 1, 0, 0, 0));
        // R11: zero-count legal write does nothing
        cfg_word = mk_cfg(16'd0, 0, 0, 0, 0, 0); cfg_we = 1;
        @(negedge clk); cfg_we = 0;
        chk(busy == 0 && err_sts == 1 && done_sts == 0, "R11", "zero count ignored",
            32'({busy, err_sts, done_sts}), 32'd2);
        // R11: launch after reject clears error; R10: writes during busy ignored
        start_xfer(10, 32'h0000_0300, 32'h0000_0400, 1, 0, 0, 0, 1);
        repeat (3) @(negedge clk);
        cfg_word = mk_cfg(16'd2, 0, 0, 1, 0, 0); cfg_we = 1; src_we = 1; dst_we = 1;
        src_wdata = 32'hDEAD_0000; dst_wdata = 32'hBEEF_0000;
        @(negedge clk); cfg_we = 0; src_we = 0; dst_we = 0;
        chk(busy == 1'b1, "R10", "still busy after ignored write", 32'(busy), 32'd1);
        finish_xfer();
        chk(wr_idx == 10, "R10", "length kept", 32'(wr_idx), 32'd10);
        // longer transfer
        start_xfer(300, 32'h0001_FF00, 32'h0002_0000, 0, 0, 0, 0, 0); finish_xfer();
        // constrained random, legal selections only
        for (int t = 0; t < 40; t++) begin
            bit ssys, sreg, dsys, dreg, fl;
            ssys = 1'($urandom); sreg = ssys ? 1'b0 : 1'($urandom);
            dsys = 1'($urandom); dreg = dsys ? 1'b0 : 1'($urandom);
            fl   = ($urandom % 4 == 0);
            start_xfer(1 + int'($urandom % 12), $urandom, $urandom, ssys, sreg, fl, dsys, dreg);
            finish_xfer();
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule